// File: doc/BRIEF.md
# Shared FIFO Port With Retry Flow Control

This block is a first-in first-out buffer that sits behind two independent I/O ports used by several hardware threads. Requesters on the push side offer a word. The buffer takes it unless it is full, in which case it raises a retry request and the requester tries again on a later cycle. Requesters on the pop side offer a command word. The command either polls whether data is waiting or asks for the head entry. If a read finds the buffer empty, the block asks for a retry.

When several requesters drive the same side in one cycle, their words are merged with a bitwise OR before the buffer sees them. Push and pop are separate ports, so a push and a pop in the same cycle do not disturb each other. A pop command with its top bit set switches the pop side into read mode for good. From then on every pop is a read, whatever the command word says, until the next reset.

All responses are combinational within the cycle of the request. The buffer state changes at the next rising clock edge.

Top module: `shared_fifo_port`

## Requirements
- R1: A push when the buffer is not full gives push_retry_o = 0, and the merged word is appended at the tail on the clock edge.
- R2: A push when the buffer is full (DEPTH entries) gives push_retry_o = 1 and stores nothing. The stored contents and their order are unchanged.
- R3: A pop in status mode (sticky flag clear, merged command bit 0 = 0, bit DATA_W-1 = 0) gives pop_retry_o = 0 and pop_result_o = 1 if the buffer holds an entry, 0 if it is empty. Nothing is removed.
- R4: A pop in read mode on a non-empty buffer gives pop_retry_o = 0 and returns the oldest entry on pop_result_o. That entry is removed, so entries leave in the order they arrived.
- R5: A pop in read mode on an empty buffer gives pop_retry_o = 1 and pop_result_o = 0, and changes nothing.
- R6: A pop whose merged command has bit DATA_W-1 set is a read in that cycle. It also sets a sticky flag, and while that flag is set every later pop is a read, whatever its command bits. Only reset clears the flag.
- R7: Push words from all requesters with push_valid_i set in a cycle are ORed into one entry. Words from requesters whose valid bit is clear have no effect.
- R8: Pop commands from all requesters with pop_valid_i set in a cycle are ORed into one command before decoding.
- R9: A push and a pop in the same cycle are handled independently. Fullness and emptiness are judged on the state before that cycle, so at one non-full, non-empty fill both succeed and the occupancy is unchanged.
- R10: After reset the buffer is empty and the sticky read flag is clear.
- R11: With no valid requester on a side, that side's retry output is 0. With no pop requester, pop_result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | NUM_REQ | Per-requester push request |
| push_data_i | input | NUM_REQ*DATA_W | Push words; requester k occupies bits [k*DATA_W +: DATA_W] |
| push_retry_o | output | 1 | Push refused because the buffer is full |
| pop_valid_i | input | NUM_REQ | Per-requester pop request |
| pop_cmd_i | input | NUM_REQ*DATA_W | Pop commands; bit 0 requests a read, bit DATA_W-1 makes read mode sticky |
| pop_retry_o | output | 1 | Read refused because the buffer is empty |
| pop_result_o | output | DATA_W | Status (0 or 1) or the head entry |

## Verification
A wrong occupancy count or a wrong pointer shows up in the same cycle at the ports. It appears as a retry on a push that should fit, a missing retry on a full or empty buffer, or a status poll that disagrees with what was stored. A pointer that slips returns a wrong or repeated word on the next read, and that read happens within DEPTH pops. A sticky flag that sets too early, or that never sets, turns the very next status poll into a read or a read into a poll. The bench therefore compares all three outputs on every cycle against a queue model, across every fill level and every requester combination.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
  typedef enum logic {
    MODE_STATUS = 1'b0,
    MODE_READ   = 1'b1
  } pop_mode_e;
endpackage

// File: rtl/req_or_merge.sv
module req_or_merge #(
  parameter int WIDTH   = 32,
  parameter int NUM_REQ = 2
) (
  input  logic [NUM_REQ-1:0]       valid_i,
  input  logic [NUM_REQ*WIDTH-1:0] word_i,
  output logic                     any_o,
  output logic [WIDTH-1:0]         merged_o
);
  logic [WIDTH-1:0] masked [NUM_REQ];

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_mask
    assign masked[k] = valid_i[k] ? word_i[k*WIDTH +: WIDTH] : '0;
  end

  always_comb begin
    merged_o = '0;
    for (int k = 0; k < NUM_REQ; k++) merged_o = merged_o | masked[k];
  end

  assign any_o = |valid_i;
endmodule

// File: rtl/fifo_ring.sv
module fifo_ring #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             wr_ok, rd_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign wr_ok   = wr_en_i && !full_o;
  assign rd_ok   = rd_en_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/pop_decoder.sv
module pop_decoder
  import fifo_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_any_i,
  input  logic [WIDTH-1:0] cmd_i,
  output pop_mode_e        mode_o,
  output logic             sticky_o
);
  logic sticky_q;
  logic unused_cmd_mid;

  assign unused_cmd_mid = ^cmd_i[WIDTH-2:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else if (pop_any_i && cmd_i[WIDTH-1]) sticky_q <= 1'b1;
  end

  // top bit acts in its own cycle as well as afterwards
  assign mode_o   = (sticky_q || cmd_i[0] || cmd_i[WIDTH-1]) ? MODE_READ : MODE_STATUS;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/shared_fifo_port.sv
module shared_fifo_port
  import fifo_port_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  parameter int NUM_REQ = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REQ-1:0]        push_valid_i,
  input  logic [NUM_REQ*DATA_W-1:0] push_data_i,
  output logic                      push_retry_o,
  input  logic [NUM_REQ-1:0]        pop_valid_i,
  input  logic [NUM_REQ*DATA_W-1:0] pop_cmd_i,
  output logic                      pop_retry_o,
  output logic [DATA_W-1:0]         pop_result_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push_any, pop_any;
  logic [DATA_W-1:0] push_word, pop_word, head;
  logic              empty, full, sticky, do_read;
  logic [CNT_W-1:0]  count;
  pop_mode_e         mode;

  req_or_merge #(.WIDTH(DATA_W), .NUM_REQ(NUM_REQ)) u_push_merge (
    .valid_i(push_valid_i), .word_i(push_data_i), .any_o(push_any), .merged_o(push_word)
  );

  req_or_merge #(.WIDTH(DATA_W), .NUM_REQ(NUM_REQ)) u_pop_merge (
    .valid_i(pop_valid_i), .word_i(pop_cmd_i), .any_o(pop_any), .merged_o(pop_word)
  );

  pop_decoder #(.WIDTH(DATA_W)) u_dec (
    .clk_i, .rst_ni, .pop_any_i(pop_any), .cmd_i(pop_word), .mode_o(mode), .sticky_o(sticky)
  );

  assign do_read = pop_any && (mode == MODE_READ);

  fifo_ring #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .wr_en_i(push_any && !full), .wr_data_i(push_word),
    .rd_en_i(do_read && !empty),
    .head_o(head), .empty_o(empty), .full_o(full), .count_o(count)
  );

  assign push_retry_o = push_any && full;
  assign pop_retry_o  = do_read && empty;

  always_comb begin
    if (!pop_any)     pop_result_o = '0;
    else if (do_read) pop_result_o = empty ? '0 : head;
    else              pop_result_o = DATA_W'(!empty);
  end
endmodule

// File: rtl/fifo_port_checker.sv
module fifo_port_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_any,
  input logic             pop_any,
  input logic             do_read,
  input logic             push_retry_o,
  input logic             pop_retry_o,
  input logic             sticky,
  input logic [CNT_W-1:0] count
);
  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  assert_retry_only_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_retry_o |-> count == CNT_W'(DEPTH));

  assert_no_store_on_retry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_retry_o |=> count <= $past(count));

  assert_read_empty_retry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_read && count == '0) |-> pop_retry_o);

  assert_status_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_any && !do_read && !push_any) |=> count == $past(count));

  assert_sticky_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky |=> sticky);

  assert_sticky_forces_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky && pop_any) |-> do_read);

  assert_both_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_any && do_read && count != '0 && count != CNT_W'(DEPTH)) |=> count == $past(count));

  assert_idle_push_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_any |-> !push_retry_o);

  assert_idle_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_any |-> !pop_retry_o);
endmodule

bind shared_fifo_port fifo_port_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_any(push_any), .pop_any(pop_any),
  .do_read(do_read), .push_retry_o(push_retry_o), .pop_retry_o(pop_retry_o),
  .sticky(sticky), .count(count)
);

// File: tb/tb_shared_fifo_port.sv
module tb_shared_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int DEPTH = 4;
  localparam int NR = 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NR-1:0]   push_valid_i = '0;
  logic [NR*W-1:0] push_data_i = '0;
  logic            push_retry_o;
  logic [NR-1:0]   pop_valid_i = '0;
  logic [NR*W-1:0] pop_cmd_i = '0;
  logic            pop_retry_o;
  logic [W-1:0]    pop_result_o;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] q[$];
  logic sticky_m = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shared_fifo_port #(.DATA_W(W), .DEPTH(DEPTH), .NUM_REQ(NR)) dut (.*);

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    push_valid_i = '0; pop_valid_i = '0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    q.delete();
    sticky_m = 1'b0;
  endtask

  // inputs applied just after a falling edge; outputs compared before the next rise
  task automatic step(input logic [1:0] pv, input logic [W-1:0] pd0, input logic [W-1:0] pd1,
                      input logic [1:0] ov, input logic [W-1:0] oc0, input logic [W-1:0] oc1,
                      input string tag);
    logic [W-1:0] pw, cw, exp_res;
    logic pany, oany, rd, exp_pr, exp_or;
    push_valid_i = pv; push_data_i = {pd1, pd0};
    pop_valid_i = ov;  pop_cmd_i = {oc1, oc0};
    #1;
    pw = (pv[0] ? pd0 : '0) | (pv[1] ? pd1 : '0);
    cw = (ov[0] ? oc0 : '0) | (ov[1] ? oc1 : '0);
    pany = |pv; oany = |ov;
    rd = oany && (sticky_m || cw[0] || cw[W-1]);
    exp_pr = pany && (q.size() == DEPTH);
    exp_or = rd && (q.size() == 0);
    if (!oany) exp_res = '0;
    else if (rd) exp_res = (q.size() == 0) ? '0 : q[0];
    else exp_res = (q.size() != 0) ? 32'd1 : 32'd0;
    check(tag, "push_retry", {31'd0, push_retry_o}, {31'd0, exp_pr});
    check(tag, "pop_retry", {31'd0, pop_retry_o}, {31'd0, exp_or});
    check(tag, "pop_result", pop_result_o, exp_res);
    @(posedge clk_i);
    if (rd && q.size() != 0) void'(q.pop_front());
    if (pany && !exp_pr) q.push_back(pw);
    if (oany && cw[W-1]) sticky_m = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic push1(input logic [W-1:0] v, input string tag);
    step(2'b01, v, '0, 2'b00, '0, '0, tag);
  endtask

  task automatic read1(input string tag);
    step(2'b00, '0, '0, 2'b01, 32'd1, '0, tag);
  endtask

  task automatic sweep(input int n, input logic allow_msb, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] c0, c1;
      seed = seed * 32'd1103515245 + 32'd12345;
      c0 = {allow_msb && (seed[20:17] == 4'd0), 30'd0, seed[5]};
      c1 = {1'b0, 30'd0, seed[6]};
      step(seed[1:0], seed ^ 32'h00ff_0000, {seed[15:0], seed[31:16]}, seed[3:2], c0, c1, tag);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    step(2'b00, 32'hdead_beef, '1, 2'b00, '1, '1, "R11");
    step(2'b00, '0, '0, 2'b01, 32'd0, '0, "R10");
    read1("R5");
    step(2'b11, 32'd1, 32'd2, 2'b00, '0, '0, "R7");
    read1("R4");
    step(2'b01, 32'd5, 32'hf0, 2'b00, '0, '0, "R7");
    read1("R7");
    for (int i = 0; i < DEPTH; i++) push1(32'd10 + i, "R1");
    push1(32'd99, "R2");
    step(2'b00, '0, '0, 2'b10, '0, 32'd0, "R3");
    for (int i = 0; i < DEPTH; i++) read1("R4");
    read1("R5");
    push1(32'd7, "R1");
    step(2'b00, '0, '0, 2'b11, 32'd0, 32'd1, "R8");
    push1(32'd21, "R9");
    push1(32'd22, "R9");
    step(2'b01, 32'd23, '0, 2'b01, 32'd1, '0, "R9");
    for (int i = 0; i < 2; i++) push1(32'd30 + i, "R9");
    step(2'b10, '0, 32'd40, 2'b01, 32'd1, '0, "R9");
    for (int i = 0; i < DEPTH + 1; i++) read1("R9");
    step(2'b01, 32'd50, '0, 2'b01, 32'd1, '0, "R9");
    read1("R9");
    sweep(600, 1'b0, "R9");
    for (int i = 0; i < DEPTH; i++) read1("R4");
    push1(32'd61, "R6");
    push1(32'd62, "R6");
    step(2'b00, '0, '0, 2'b01, 32'h8000_0000, '0, "R6");
    step(2'b00, '0, '0, 2'b01, 32'd0, '0, "R6");
    step(2'b00, '0, '0, 2'b10, '0, 32'd0, "R6");
    sweep(300, 1'b1, "R6");
    do_reset();
    @(negedge clk_i);
    push1(32'd70, "R10");
    step(2'b00, '0, '0, 2'b01, 32'd0, '0, "R10");
    step(2'b00, '0, '0, 2'b01, 32'd0, '0, "R6");
    sweep(300, 1'b1, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule